// File: doc/BRIEF.md
# Reset and Power-Down Sequencer

This block sits behind the active-low reset/power-down pin of a flash-style memory and decides, cycle by cycle, what the rest of the device may do. When the pin is pulled low for long enough, the sequencer stops the program/erase engine, holds the status register in its cleared state and refuses every command write. It then parks the device in deep power-down. A short low pulse is treated as noise and has no effect. How long the shutdown takes depends on the engine: an idle engine is shut down after a short interval. A running program or erase needs a much longer abort interval before power-down is reached.

When the pin is released, the sequencer runs a recovery count. The count starts only once the pin is high and the engine no longer reports busy, whichever of the two comes last. Reads are qualified as valid after a read-recovery interval. Command writes are accepted only after a longer write-recovery interval. A new low level during recovery sends the device straight back to power-down, and both intervals begin again from zero. While in power-down the ready/busy output reads as ready. Outside power-down it follows the engine. All intervals are parameters counted in clock cycles. The pin passes through a synchronizer of SYNC_STAGES flops before any of these counts starts.

Top module: `pwrdn_seq`

## Requirements
- R1: After the sequencer's own reset, the device is in power-down: pd_active=1, status_clear=1, ready_out=1, read_valid=0, write_accept=0, engine_abort=0.
- R2: A low pulse on pd_pin_n that is sampled low on fewer than MIN_LOW consecutive clock edges is ignored: write_accept and read_valid stay 1 and pd_active stays 0.
- R3: When pd_pin_n is sampled low on MIN_LOW consecutive edges, write_accept and read_valid fall SYNC_STAGES+MIN_LOW cycles after the pin falls. engine_abort and status_clear go to 1 in that same cycle, and status_clear stays 1 throughout power-down.
- R4: With engine_busy=0 when the low level is recognised, pd_active rises IDLE_ENTER cycles after write_accept falls, and engine_abort then returns to 0.
- R5: With engine_busy=1 when the low level is recognised, pd_active rises BUSY_ENTER cycles after write_accept falls.
- R6: ready_out is 1 whenever pd_active is 1, whatever the value of engine_busy. Otherwise ready_out equals the inverse of engine_busy.
- R7: Recovery starts on the first cycle in which the synchronised pin is high and engine_busy is 0. read_valid rises READ_REC cycles after recovery starts. If the pin is released first, read_valid rises 1+READ_REC cycles after engine_busy falls. If engine_busy is already 0, it rises SYNC_STAGES+1+READ_REC cycles after the pin rises.
- R8: write_accept rises WRITE_REC cycles after recovery starts, that is WRITE_REC-READ_REC cycles after read_valid. write_accept is never 1 while read_valid is 0.
- R9: A low level on the synchronised pin during recovery returns the device to power-down on the next edge, with read_valid=0. That is SYNC_STAGES+1 cycles after the pin falls. A later release runs both recovery intervals again in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the sequencer logic |
| pd_pin_n | input | 1 | Raw active-low reset/power-down pin |
| engine_busy | input | 1 | Program/erase engine is running |
| pd_active | output | 1 | Device is held in deep power-down |
| engine_abort | output | 1 | Abort request to the program/erase engine during shutdown |
| status_clear | output | 1 | Holds the status register cleared |
| read_valid | output | 1 | Read data may be returned |
| write_accept | output | 1 | Command writes are recognised |
| ready_out | output | 1 | Ready/busy indication, 1 = ready |

## Verification
The assertions assume that engine_busy changes only on clock-synchronous boundaries. They also assume the pin is the only path into power-down, so every fall of write_accept is traced back to a synchronised low level and every entry into power-down is traced back to an abort interval or a low level during recovery. The bench drives both inputs on falling clock edges, so no input change coincides with a sampling edge. It moves engine_busy only at the points where a real engine would: before a shutdown, and low again once power-down is reached. Glitch widths are chosen on both sides of the MIN_LOW boundary.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
   typedef enum logic [1:0] {
      SEQ_RUN   = 2'd0,
      SEQ_ENTER = 2'd1,
      SEQ_PD    = 2'd2,
      SEQ_RECOV = 2'd3
   } seq_state_e;
endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("pwrdn_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge sys_rst_n) begin
         if (!sys_rst_n) chain <= '0;
         else            chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/pwrdn_low_filter.sv
module pwrdn_low_filter #(
   parameter int MIN_LOW = 4
) (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic pin_s,
   output logic hit
);
   if (MIN_LOW < 1) begin : g_bad_min
      $error("pwrdn_low_filter: MIN_LOW must be at least 1");
   end

   if (MIN_LOW == 1) begin : g_direct
      assign hit = !pin_s;
   end else begin : g_count
      localparam int CW = $clog2(MIN_LOW);
      localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);
      logic [CW-1:0] low_cnt;

      always_ff @(posedge clk or negedge sys_rst_n) begin
         if (!sys_rst_n)          low_cnt <= '0;
         else if (pin_s)          low_cnt <= '0;
         else if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;
      end

      assign hit = !pin_s && (low_cnt == LAST);

      assert_hit_after_low_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
         $rose(hit) |-> $past(!pin_s));
   end
endmodule

// File: rtl/pwrdn_entry_timer.sv
module pwrdn_entry_timer #(
   parameter int IDLE_ENTER = 5,
   parameter int BUSY_ENTER = 600
) (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic start,
   input  logic long_sel,
   output logic expire
);
   localparam int CW = $clog2(BUSY_ENTER + 1);
   localparam logic [CW-1:0] IDLE_LOAD = CW'(IDLE_ENTER - 1);
   localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_ENTER - 1);

   if (IDLE_ENTER < 1 || BUSY_ENTER < IDLE_ENTER) begin : g_bad_enter
      $error("pwrdn_entry_timer: need 1 <= IDLE_ENTER <= BUSY_ENTER");
   end

   logic [CW-1:0] cnt;
   logic          running;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (start) begin
         cnt     <= long_sel ? BUSY_LOAD : IDLE_LOAD;
         running <= 1'b1;
      end else if (running) begin
         if (cnt == '0) running <= 1'b0;
         else           cnt     <= cnt - 1'b1;
      end
   end

   assign expire = running && (cnt == '0);

   assert_one_entry_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
      start |-> !running);
endmodule

// File: rtl/pwrdn_recovery_timer.sv
module pwrdn_recovery_timer #(
   parameter int READ_REC  = 20,
   parameter int WRITE_REC = 50
) (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic clear,
   output logic read_ok,
   output logic write_due
);
   localparam int CW = $clog2(WRITE_REC + 1);
   localparam logic [CW-1:0] RD_AT  = CW'(READ_REC);
   localparam logic [CW-1:0] WR_AT  = CW'(WRITE_REC - 1);
   localparam logic [CW-1:0] SAT_AT = CW'(WRITE_REC);

   if (READ_REC < 1 || WRITE_REC <= READ_REC) begin : g_bad_rec
      $error("pwrdn_recovery_timer: need 1 <= READ_REC < WRITE_REC");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n)         cnt <= '0;
      else if (clear)         cnt <= '0;
      else if (cnt != SAT_AT) cnt <= cnt + 1'b1;
   end

   assign read_ok   = cnt >= RD_AT;
   assign write_due = cnt >= WR_AT;

   assert_count_forward_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (!clear && $past(!clear)) |-> (cnt >= $past(cnt)));
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
   import pwrdn_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW     = 4,
   parameter int IDLE_ENTER  = 5,
   parameter int BUSY_ENTER  = 600,
   parameter int READ_REC    = 20,
   parameter int WRITE_REC   = 50
) (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic pd_pin_n,
   input  logic engine_busy,
   output logic pd_active,
   output logic engine_abort,
   output logic status_clear,
   output logic read_valid,
   output logic write_accept,
   output logic ready_out
);
   seq_state_e state, state_nx;
   logic pin_s, hit, expire, read_ok, write_due, enter_start;

   pwrdn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .sys_rst_n(sys_rst_n), .d(pd_pin_n), .q(pin_s));

   pwrdn_low_filter #(.MIN_LOW(MIN_LOW)) u_filter (
      .clk(clk), .sys_rst_n(sys_rst_n), .pin_s(pin_s), .hit(hit));

   assign enter_start = (state == SEQ_RUN) && hit;

   pwrdn_entry_timer #(.IDLE_ENTER(IDLE_ENTER), .BUSY_ENTER(BUSY_ENTER)) u_enter (
      .clk(clk), .sys_rst_n(sys_rst_n), .start(enter_start),
      .long_sel(engine_busy), .expire(expire));

   pwrdn_recovery_timer #(.READ_REC(READ_REC), .WRITE_REC(WRITE_REC)) u_recov (
      .clk(clk), .sys_rst_n(sys_rst_n), .clear(state != SEQ_RECOV),
      .read_ok(read_ok), .write_due(write_due));

   always_comb begin
      state_nx = state;
      unique case (state)
         SEQ_RUN:   if (hit) state_nx = SEQ_ENTER;
         SEQ_ENTER: if (expire) state_nx = SEQ_PD;
         SEQ_PD:    if (pin_s && !engine_busy) state_nx = SEQ_RECOV;
         SEQ_RECOV: begin
            if (!pin_s)         state_nx = SEQ_PD;
            else if (write_due) state_nx = SEQ_RUN;
         end
         default:   state_nx = SEQ_PD;
      endcase
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) state <= SEQ_PD;
      else            state <= state_nx;
   end

   assign pd_active    = (state == SEQ_PD);
   assign engine_abort = (state == SEQ_ENTER);
   assign status_clear = (state == SEQ_ENTER) || (state == SEQ_PD);
   assign write_accept = (state == SEQ_RUN);
   assign read_valid   = (state == SEQ_RUN) || ((state == SEQ_RECOV) && read_ok);
   assign ready_out    = pd_active ? 1'b1 : !engine_busy;

   assert_drop_needs_low_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
      $fell(write_accept) |-> $past(!pin_s));
   assert_abort_blocks_access_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
      engine_abort |-> (!read_valid && !write_accept));
   assert_pd_clears_status_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
      pd_active |-> status_clear);
   assert_ready_in_pd_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
      pd_active |-> ready_out);
   assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
      $rose(write_accept) |-> $past(read_valid));
   assert_write_needs_read_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
      write_accept |-> read_valid);
   assert_pd_entry_cause_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
      $rose(pd_active) |-> ($past(engine_abort) || $past(!pin_s)));
endmodule

// File: tb/pwrdn_seq_test.sv
module pwrdn_seq_test;
   localparam int SYNC = 2, MINL = 4, IDLE = 5, BUSY = 600, RREC = 20, WREC = 50;

   logic clk = 1'b0, sys_rst_n = 1'b0, pd_pin_n = 1'b0, engine_busy = 1'b0;
   logic pd_active, engine_abort, status_clear, read_valid, write_accept, ready_out;
   int n_checks = 0, n_fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwrdn_seq #(.SYNC_STAGES(SYNC), .MIN_LOW(MINL), .IDLE_ENTER(IDLE),
      .BUSY_ENTER(BUSY), .READ_REC(RREC), .WRITE_REC(WREC)) uut (
      .clk(clk), .sys_rst_n(sys_rst_n), .pd_pin_n(pd_pin_n), .engine_busy(engine_busy),
      .pd_active(pd_active), .engine_abort(engine_abort), .status_clear(status_clear),
      .read_valid(read_valid), .write_accept(write_accept), .ready_out(ready_out));

   // {expect recognised, low width in cycles}
   localparam logic [8:0] GLITCH_TAB [5] = '{
      {1'b0, 8'd1}, {1'b0, 8'd2}, {1'b0, 8'd3}, {1'b1, 8'd4}, {1'b1, 8'd7}};

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic pick(input int sel);
      case (sel)
         0: return read_valid;
         1: return write_accept;
         default: return pd_active;
      endcase
   endfunction

   task automatic wait_for(input int sel, input logic lvl, input int limit, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (pick(sel) != lvl && n < limit);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      sys_rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pd_active", pd_active, 1);
      check("R1 status_clear", status_clear, 1);
      check("R1 ready_out", ready_out, 1);
      check("R1 read_valid", read_valid, 0);
      check("R1 write_accept", write_accept, 0);
      check("R1 engine_abort", engine_abort, 0);

      // first release: R7 and R8 latencies
      pd_pin_n = 1'b1;
      wait_for(0, 1'b1, 200, n);
      check("R7 read latency", n, SYNC + 1 + RREC);
      check("R8 write_accept low while recovering", write_accept, 0);
      wait_for(1, 1'b1, 200, n);
      check("R8 write latency", n, WREC - RREC);

      // glitch table walk: R2 (ignored) and R3 (recognised)
      for (int i = 0; i < 5; i++) begin
         int len = int'(GLITCH_TAB[i][7:0]);
         bit exp_hit = GLITCH_TAB[i][8];
         bit dropped = 1'b0;
         @(negedge clk);
         pd_pin_n = 1'b0;
         if (write_accept == 1'b0) dropped = 1'b1;
         repeat (len) begin
            @(negedge clk);
            if (write_accept == 1'b0) dropped = 1'b1;
         end
         pd_pin_n = 1'b1;
         repeat (16) begin
            @(negedge clk);
            if (write_accept == 1'b0) dropped = 1'b1;
         end
         check(exp_hit ? "R3 width recognised" : "R2 glitch ignored", dropped, exp_hit);
         if (!exp_hit) check("R2 read_valid kept", read_valid, 1);
         if (dropped) wait_for(1, 1'b1, 300, n);
      end

      // R3/R4 idle shutdown
      @(negedge clk);
      pd_pin_n = 1'b0;
      wait_for(1, 1'b0, 100, n);
      check("R3 shutdown latency", n, SYNC + MINL);
      check("R3 read_valid dropped", read_valid, 0);
      check("R3 engine_abort", engine_abort, 1);
      check("R3 status_clear", status_clear, 1);
      wait_for(2, 1'b1, 100, n);
      check("R4 idle entry length", n, IDLE);
      check("R4 abort released", engine_abort, 0);
      check("R3 status_clear in pd", status_clear, 1);

      // R9 restart during recovery
      pd_pin_n = 1'b1;
      wait_for(0, 1'b1, 200, n);
      check("R9 first read latency", n, SYNC + 1 + RREC);
      pd_pin_n = 1'b0;
      wait_for(2, 1'b1, 50, n);
      check("R9 back to pd latency", n, SYNC + 1);
      check("R9 read_valid cleared", read_valid, 0);
      @(negedge clk);
      pd_pin_n = 1'b1;
      wait_for(0, 1'b1, 200, n);
      check("R9 read interval rerun", n, SYNC + 1 + RREC);
      wait_for(1, 1'b1, 200, n);
      check("R9 write interval rerun", n, WREC - RREC);

      // R6 ready follows engine while running
      @(negedge clk);
      engine_busy = 1'b1;
      @(negedge clk);
      check("R6 ready low when busy", ready_out, 0);

      // R5 busy shutdown
      pd_pin_n = 1'b0;
      wait_for(1, 1'b0, 100, n);
      check("R3 busy shutdown latency", n, SYNC + MINL);
      check("R6 ready low during abort", ready_out, 0);
      wait_for(2, 1'b1, 1000, n);
      check("R5 busy entry length", n, BUSY);
      check("R6 ready forced in pd", ready_out, 1);

      // R7 later of pin release and engine idle
      pd_pin_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R7 held while busy", pd_active, 1);
      check("R7 no read while busy", read_valid, 0);
      engine_busy = 1'b0;
      wait_for(0, 1'b1, 200, n);
      check("R7 read latency after busy low", n, 1 + RREC);
      wait_for(1, 1'b1, 200, n);
      check("R8 write after busy release", n, WREC - RREC);
      check("R6 ready when idle", ready_out, 1);

      summary();
   end
endmodule